// File: doc/BRIEF.md
# Configurable PLD Output Macrocell Bank

This block holds the output cells of a sum-of-products programmable logic device. Each lane takes the OR of its product terms (`sop_term`) and a per-lane output-enable product term. It drives one three-state pad, shown here as separate data, enable and pad-sense signals, and it returns a feedback bit to the logic array. All lanes share a clock, an asynchronous clear term, a synchronous set term and a test preload strobe.

Each lane has two configuration bits. Bit 1 selects whether the pad follows a D flip-flop or follows the sum term directly. Bit 0 selects active-high or active-low output. The clear and set terms act on the flip-flop, not on the pad, so the level on the pad always passes through the polarity stage. The feedback comes from the flip-flop in registered mode and from the pad in combinational mode. A combinational lane whose enable term stays low therefore works as a plain input. Preload copies the pad level into the flip-flop, so a test can place a state machine in any state without a long vector sequence.

Top module: `pld_out_cell`

## Requirements
- R1: Lane i uses `cfg_mode[2i+1:2i]`, with bit 1 as bypass and bit 0 as polarity. The codes are 00 = registered, pad shows the inverted flip-flop; 01 = registered, pad shows the flip-flop; 10 = combinational, pad shows the inverted `sop_term`; 11 = combinational, pad shows `sop_term`.
- R2: With no clear, set, preload or `rst_n` active, each flip-flop takes its `sop_term` bit on the rising clock edge.
- R3: `fb_out` equals the flip-flop value in registered modes (bit 1 = 0) and equals `pad_in` in combinational modes (bit 1 = 1).
- R4: While `async_clr` is high, every flip-flop reads 0 at once, with no clock edge needed. It stays 0 at an edge even when `sync_set` or `preload_en` is also high.
- R5: When `sync_set` is high, and no clear, preload or reset is active, every flip-flop reads 1 after the next rising edge.
- R6: Clear and set change only the flip-flop. An active-low registered lane shows 1 on `pad_out` when its flip-flop is cleared, and 0 when it is set.
- R7: `pad_oe` follows `oe_term` lane for lane. A combinational lane with its enable low passes the externally driven pad level to `fb_out`.
- R8: A rising edge with `rst_n` low sets every flip-flop to 0. This is the power-up state.
- R9: When `preload_en` is high at a rising edge, each flip-flop loads its `pad_in` bit. Preload takes priority over `sync_set` and over the D input, but not over `async_clr` or `rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flip-flops load on the rising edge |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| cfg_mode | input | 2*LANES | Per-lane mode bits {bypass, polarity} |
| sop_term | input | LANES | Sum-of-products result per lane |
| oe_term | input | LANES | Output-enable product term per lane |
| async_clr | input | 1 | Shared asynchronous clear term |
| sync_set | input | 1 | Shared synchronous set term |
| preload_en | input | 1 | Test strobe that loads the flip-flops from the pads |
| pad_in | input | LANES | Level sensed on each pad |
| pad_out | output | LANES | Data driven toward each pad |
| pad_oe | output | LANES | Three-state enable per pad |
| fb_out | output | LANES | Feedback to the logic array |

## Verification
The assertions check on every cycle:
- the immediate effect of the clear term;
- the next-edge result of set, preload and ordinary loads, with their priority;
- the feedback source in each mode, compared with what the pad shows.

Only the bench scenarios can show:
- the power-up value;
- a clear raised in the middle of a cycle, seen before any edge;
- a lane behaving as a dedicated input while its enable is low;
- the pad levels in every mode, including the inverted idle level of an active-low lane after reset.

// File: rtl/pld_out_cell_pkg.sv
// Shared types for the output macrocell bank.
// Assumes bit 1 of a mode pair selects bypass and bit 0 selects polarity.
package pld_out_cell_pkg;
    typedef enum logic [1:0] {
        MODE_REG_LOW   = 2'b00,
        MODE_REG_HIGH  = 2'b01,
        MODE_COMB_LOW  = 2'b10,
        MODE_COMB_HIGH = 2'b11
    } cell_mode_t;

    typedef struct packed {
        logic bypass;
        logic pol_high;
    } cell_cfg_t;

    function automatic cell_cfg_t decode_mode(input logic [1:0] bits);
        cell_mode_t m;
        m = cell_mode_t'(bits);
        decode_mode.bypass   = (m == MODE_COMB_LOW) || (m == MODE_COMB_HIGH);
        decode_mode.pol_high = (m == MODE_REG_HIGH) || (m == MODE_COMB_HIGH);
    endfunction
endpackage

// File: rtl/pld_cell_store.sv
// D flip-flop of one macrocell.
// Priority: async clear, then sync reset, then preload, then set, then D.
// Assumes the clear term is glitch-free, since it is used as an async input.
module pld_cell_store (
    input  logic clk,
    input  logic rst_n,
    input  logic async_clr,
    input  logic sync_set,
    input  logic preload_en,
    input  logic preload_val,
    input  logic d_in,
    output logic q
);
    // State update: the clear acts at once, everything else acts on the edge.
    always_ff @(posedge clk or posedge async_clr) begin
        if (async_clr)       q <= 1'b0;
        else if (!rst_n)     q <= 1'b0;
        else if (preload_en) q <= preload_val;
        else if (sync_set)   q <= 1'b1;
        else                 q <= d_in;
    end
endmodule

// File: rtl/pld_cell_drive.sv
// Output path of one macrocell: the bypass mux, then the polarity stage.
// Assumes the enable term passes through unchanged to the three-state buffer.
module pld_cell_drive (
    input  logic bypass,
    input  logic pol_high,
    input  logic sop,
    input  logic q,
    input  logic oe,
    output logic pad_out,
    output logic pad_oe
);
    logic core;

    // Pick the source, then apply the selected polarity.
    always_comb begin
        core    = bypass ? sop : q;
        pad_out = pol_high ? core : ~core;
        pad_oe  = oe;
    end
endmodule

// File: rtl/pld_cell_feedback.sv
// Feedback select: the flip-flop in registered mode, the pad in combinational mode.
// Assumes pad_in is the resolved pad level, whoever is driving it.
module pld_cell_feedback (
    input  logic bypass,
    input  logic q,
    input  logic pad_in,
    output logic fb
);
    // Route the chosen source back to the array.
    always_comb fb = bypass ? pad_in : q;
endmodule

// File: rtl/pld_out_cell.sv
// Bank of LANES output macrocells sharing the clock, clear, set and preload terms.
// Assumes cfg_mode is static during normal use; a change takes effect at once.
module pld_out_cell #(
    parameter int LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*LANES-1:0]   cfg_mode,
    input  logic [LANES-1:0]     sop_term,
    input  logic [LANES-1:0]     oe_term,
    input  logic                 async_clr,
    input  logic                 sync_set,
    input  logic                 preload_en,
    input  logic [LANES-1:0]     pad_in,
    output logic [LANES-1:0]     pad_out,
    output logic [LANES-1:0]     pad_oe,
    output logic [LANES-1:0]     fb_out
);
    import pld_out_cell_pkg::*;

    localparam int CFG_W = 2 * LANES;

    logic [LANES-1:0] reg_q;
    cell_cfg_t        lane_cfg [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Decode this lane's pair of mode bits.
        always_comb lane_cfg[i] = decode_mode(cfg_mode[2*i +: 2]);

        pld_cell_store u_store (
            .clk        (clk),
            .rst_n      (rst_n),
            .async_clr  (async_clr),
            .sync_set   (sync_set),
            .preload_en (preload_en),
            .preload_val(pad_in[i]),
            .d_in       (sop_term[i]),
            .q          (reg_q[i])
        );

        pld_cell_drive u_drive (
            .bypass  (lane_cfg[i].bypass),
            .pol_high(lane_cfg[i].pol_high),
            .sop     (sop_term[i]),
            .q       (reg_q[i]),
            .oe      (oe_term[i]),
            .pad_out (pad_out[i]),
            .pad_oe  (pad_oe[i])
        );

        pld_cell_feedback u_fb (
            .bypass(lane_cfg[i].bypass),
            .q     (reg_q[i]),
            .pad_in(pad_in[i]),
            .fb    (fb_out[i])
        );
    end

    logic unused_w;
    always_comb unused_w = ^CFG_W;
endmodule

// File: rtl/pld_out_cell_chk.sv
// Checker for pld_out_cell: register priorities and feedback routing, lane by lane.
// Assumes it is bound to the top and sees the internal flip-flop vector.
module pld_out_cell_chk #(
    parameter int LANES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*LANES-1:0]   cfg_mode,
    input logic [LANES-1:0]     sop_term,
    input logic                 async_clr,
    input logic                 sync_set,
    input logic                 preload_en,
    input logic [LANES-1:0]     pad_in,
    input logic [LANES-1:0]     pad_out,
    input logic [LANES-1:0]     fb_out,
    input logic [LANES-1:0]     reg_q
);
    for (genvar i = 0; i < LANES; i++) begin : g_chk
        // R4
        clr_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
            async_clr |-> reg_q[i] == 1'b0);
        // R5
        set_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!async_clr && !preload_en && sync_set) |=> (async_clr || reg_q[i]));
        // R9
        preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!async_clr && preload_en) |=> (async_clr || reg_q[i] == $past(pad_in[i])));
        // R2
        d_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!async_clr && !preload_en && !sync_set) |=> (async_clr || reg_q[i] == $past(sop_term[i])));
        // R3
        fb_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_mode[2*i+1] |-> fb_out[i] == pad_in[i]);
        // R6
        fb_reg_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_mode[2*i+1] |-> fb_out[i] == (cfg_mode[2*i] ? pad_out[i] : !pad_out[i]));
    end
endmodule

bind pld_out_cell pld_out_cell_chk #(.LANES(LANES)) u_pld_out_cell_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .sop_term  (sop_term),
    .async_clr (async_clr),
    .sync_set  (sync_set),
    .preload_en(preload_en),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .fb_out    (fb_out),
    .reg_q     (reg_q)
);

// File: tb/test_pld_out_cell.sv
`timescale 1ns/100ps
module test_pld_out_cell;
    localparam int LANES = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic [2*LANES-1:0] cfg_mode;
    logic [LANES-1:0] sop_term, oe_term, ext_drv, pad_in, pad_out, pad_oe, fb_out;
    logic async_clr, sync_set, preload_en;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit model_ok = 0;
    bit mq [LANES];

    always #2.5 clk = ~clk;

    // Pad resolution: the cell drives the pad when enabled, the outside world otherwise.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_drv);

    pld_out_cell #(.LANES(LANES)) i_pld_out_cell (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .sop_term(sop_term),
        .oe_term(oe_term), .async_clr(async_clr), .sync_set(sync_set),
        .preload_en(preload_en), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .fb_out(fb_out)
    );

    function automatic bit exp_out(int i);
        bit core;
        core = cfg_mode[2*i+1] ? sop_term[i] : mq[i];
        return cfg_mode[2*i] ? core : !core;
    endfunction

    function automatic bit exp_pad(int i);
        return oe_term[i] ? exp_out(i) : ext_drv[i];
    endfunction

    function automatic bit exp_fb(int i);
        return cfg_mode[2*i+1] ? exp_pad(i) : mq[i];
    endfunction

    task automatic check(string tag);
        if (!model_ok) return;
        for (int i = 0; i < LANES; i++) begin
            compared++;
            if (pad_out[i] !== exp_out(i) || fb_out[i] !== exp_fb(i) || pad_oe[i] !== oe_term[i]) begin
                mismatched++;
                $display("FAIL %s lane %0d: out/fb/oe = %b/%b/%b expected %b/%b/%b", tag, i,
                         pad_out[i], fb_out[i], pad_oe[i], exp_out(i), exp_fb(i), oe_term[i]);
            end
        end
    endtask

    // One cycle: apply inputs, check before the edge, update the model, check after it.
    task automatic cyc(string tag, logic r, logic [3:0] cfg, logic [1:0] sop, logic [1:0] oe,
                       logic [1:0] ext, logic clr, logic set, logic pl);
        bit nq [LANES];
        rst_n = r; cfg_mode = cfg; sop_term = sop; oe_term = oe; ext_drv = ext;
        async_clr = clr; sync_set = set; preload_en = pl;
        if (clr) for (int i = 0; i < LANES; i++) mq[i] = 0;
        #0.5;
        check(tag);
        for (int i = 0; i < LANES; i++) begin
            if (clr || !r) nq[i] = 0;
            else if (pl)   nq[i] = exp_pad(i);
            else if (set)  nq[i] = 1;
            else           nq[i] = sop[i];
        end
        @(posedge clk);
        mq = nq;
        if (!r) model_ok = 1;
        #1;
        check(tag);
    endtask

    initial begin
        rst_n = 0; cfg_mode = '0; sop_term = '0; oe_term = '0; ext_drv = '0;
        async_clr = 0; sync_set = 0; preload_en = 0;
        @(posedge clk); #1;
        // R8 power-up state; R6 active-low lane 0 shows 1 after reset
        cyc("R8", 0, 4'b0100, 2'b11, 2'b11, 2'b00, 0, 0, 0);
        cyc("R8", 0, 4'b0100, 2'b11, 2'b11, 2'b00, 0, 0, 0);
        cyc("R6", 1, 4'b0100, 2'b00, 2'b11, 2'b00, 0, 0, 0);
        // R2 edge loads with several patterns; R1 registered polarities
        cyc("R2", 1, 4'b0100, 2'b01, 2'b11, 2'b00, 0, 0, 0);
        cyc("R2", 1, 4'b0100, 2'b10, 2'b11, 2'b00, 0, 0, 0);
        cyc("R1", 1, 4'b0001, 2'b11, 2'b11, 2'b00, 0, 0, 0);
        // R5 set; R6 set shows 0 on an active-low lane
        cyc("R5", 1, 4'b0100, 2'b00, 2'b11, 2'b00, 0, 1, 0);
        cyc("R6", 1, 4'b0100, 2'b00, 2'b11, 2'b00, 0, 1, 0);
        // R4 clear mid-cycle wins over set
        cyc("R4", 1, 4'b0100, 2'b11, 2'b11, 2'b00, 1, 1, 0);
        cyc("R4", 1, 4'b0100, 2'b11, 2'b11, 2'b00, 0, 0, 0);
        // R9 preload from externally driven pads beats set and D
        cyc("R9", 1, 4'b0100, 2'b01, 2'b00, 2'b10, 0, 1, 1);
        cyc("R9", 1, 4'b0100, 2'b01, 2'b00, 2'b01, 0, 0, 1);
        // R9 clear beats preload
        cyc("R9", 1, 4'b0100, 2'b01, 2'b00, 2'b11, 1, 0, 1);
        // R9 sync reset beats preload
        cyc("R9", 1, 4'b0100, 2'b00, 2'b00, 2'b11, 0, 0, 1);
        cyc("R9", 0, 4'b0100, 2'b00, 2'b00, 2'b11, 0, 0, 1);
        // R1 combinational modes; R3 feedback from the driven pad
        cyc("R1", 1, 4'b1110, 2'b01, 2'b11, 2'b00, 0, 0, 0);
        cyc("R3", 1, 4'b1011, 2'b10, 2'b11, 2'b00, 0, 0, 0);
        // R7 enable low: the lane is a dedicated input
        cyc("R7", 1, 4'b1110, 2'b11, 2'b00, 2'b10, 0, 0, 0);
        cyc("R7", 1, 4'b1110, 2'b00, 2'b01, 2'b01, 0, 0, 0);
        // Mixed stimulus over all rules; clear is kept rare
        for (int n = 0; n < 400; n++) begin
            cyc("R1/R2/R3", ($urandom % 32) != 0, 4'($urandom), 2'($urandom), 2'($urandom),
                2'($urandom), ($urandom % 16) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule